// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block runs the power-up initialization of DDR SDRAM, one physical rank after another. A pulse on `start` sets it running. It first waits for the supply and clock to settle with the memory clock enable held low and no refresh issued. It then raises clock enable and waits a second interval. After that it walks every rank through a fixed list of command-mode selections. Each selection is paired with a single dummy access. The memory controller turns that access into the real DRAM command, and its address carries the command operands.

The base address of each rank comes from the cumulative rank end-address values. An end value counts in units of 16 MB. The last mode-register access carries the mode word, and the CAS latency chosen at start picks that word. The word is placed three bits up because the three low address bits select a byte within a 64-bit data word. When the last rank has switched to normal mode, the sequencer raises `done` and holds it.

Top module: `ddr_init_seq`

## Requirements
- R1: During reset and after it, `cmd` is 0 (idle), `acc_stb` is 0 and `done` is 0 until `start` is seen.
- R2: When `start` is seen, `cmd` is 1 (power wait, clock enable low, refresh off) for T_PWR cycles. Then `cmd` is 2 (clock enable on) for T_PWR cycles, with no access strobe in either phase.
- R3: Each rank runs these command codes and address offsets from the rank base, in this order. NOP (3) at 0x1F000. Precharge-all (4) at 0x1F000. Mode-register-set (5) at 0x2000, then 0x800. Precharge-all (4) at 0x1F200. Eight auto-refresh (6) steps at 0x1F300, 0x1F400 and so on up to 0x1FA00. A final mode-register-set (5). Normal mode (7) with no access.
- R4: Each step strobes `acc_stb` only in its first cycle. NOP, both precharge steps and the final mode step last T_STEP cycles. The first two mode steps last T_MRS cycles each. Each refresh step lasts T_REF cycles. The normal-mode step lasts one cycle.
- R5: The offset of the final mode step is the mode word, set by `cas_sel` as sampled at start: 0 gives 0x150 (CAS 2), 1 gives 0x350 (CAS 2.5), 2 or 3 gives 0x1D0 (CAS 3). The word holds the CAS code in bits 9:7 (010 = 2, 110 = 2.5, 011 = 3), interleaved burst in bit 6, and burst length 4 (010) in bits 5:3.
- R6: The number of ranks run equals `rank_cnt`. A count of 0 runs one rank, and a count above MAX_RANKS runs MAX_RANKS ranks.
- R7: Rank 0 has base 0. The base of rank r+1 is byte r of `rank_end` (bits 8r+7:8r) times 16 MB, that is, shifted left by 24.
- R8: In the cycle after the last rank's normal-mode step, `done` rises with `cmd` = 7 and no strobe. Both hold until the next `start`, which begins a new run. A `start` seen while a run is in progress has no effect.
- R9: Changes on `cas_sel` and `rank_cnt` after start do not affect the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin initialization (sampled when idle or done) |
| cas_sel | input | 2 | CAS latency choice: 0 = 2, 1 = 2.5, 2/3 = 3 |
| rank_cnt | input | RC_W | Number of physical ranks |
| rank_end | input | MAX_RANKS*END_W | Cumulative rank end values, byte r for rank r, 16 MB units |
| cmd | output | 3 | Command-mode code |
| acc_stb | output | 1 | One-cycle dummy access strobe |
| acc_addr | output | ADDR_W | Dummy access address |
| done | output | 1 | Initialization complete |

## Verification
The outputs decode the state registers without any further register stage. A `start` seen at one clock edge therefore shows `cmd` = 1 right after that edge. Every later step starts exactly as many cycles after the one before it as the listed lengths add up to, and `done` rises one cycle after the last normal-mode cycle. The bench drives inputs at falling edges and samples the outputs at every falling edge of each run. It compares the command and strobe in every cycle, and the address and strobe in each step's first cycle, against a step table built from the requirements. One cycle of drift therefore fails the step it falls in. The same cycle-exact walk checks the start pulse and the input changes made in the middle of a run, because the timeline must come out unchanged.

// File: rtl/ddr_init_seq.sv
module ddr_init_seq #(
  parameter int ADDR_W    = 32,
  parameter int END_W     = 8,
  parameter int MAX_RANKS = 4,
  parameter int RC_W      = 3,
  parameter int GRAN_LOG2 = 24,
  parameter int T_PWR     = 20000,
  parameter int T_MRS     = 100,
  parameter int T_REF     = 10000,
  parameter int T_STEP    = 4,
  parameter logic [2:0] BL_CODE = 3'b010,
  parameter logic BT_ILV  = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [1:0]                   cas_sel,
  input  logic [RC_W-1:0]              rank_cnt,
  input  logic [MAX_RANKS*END_W-1:0]   rank_end,
  output logic [2:0]                   cmd,
  output logic                         acc_stb,
  output logic [ADDR_W-1:0]            acc_addr,
  output logic                         done
);
  localparam int T_A   = (T_PWR > T_REF) ? T_PWR : T_REF;
  localparam int T_B   = (T_MRS > T_STEP) ? T_MRS : T_STEP;
  localparam int T_MAX = (T_A > T_B) ? T_A : T_B;
  localparam int TW    = $clog2(T_MAX + 1);
  localparam int RW    = (MAX_RANKS > 1) ? $clog2(MAX_RANKS) : 1;
  localparam logic [3:0] LAST_STEP = 4'd14;

  typedef enum logic [2:0] {PH_IDLE, PH_PWR, PH_CKE, PH_RANK, PH_DONE} phase_t;

  phase_t            phase;
  logic [3:0]        step;
  logic [TW-1:0]     timer, step_end;
  logic [RW-1:0]     rank, last, last_d;
  logic [1:0]        cas_q;
  logic [ADDR_W-1:0] base, off;
  logic [2:0]        cl_code;
  logic              step_over;

  always_comb begin
    if (rank_cnt == '0)                   last_d = '0;
    else if (int'(rank_cnt) > MAX_RANKS)  last_d = RW'(MAX_RANKS - 1);
    else                                  last_d = RW'(rank_cnt - 1'b1);
  end

  always_comb begin
    case (cas_q)
      2'd0:    cl_code = 3'b010;
      2'd1:    cl_code = 3'b110;
      default: cl_code = 3'b011;
    endcase
  end

  always_comb begin
    step_end = TW'(T_STEP - 1);
    if (phase == PH_PWR || phase == PH_CKE) step_end = TW'(T_PWR - 1);
    else if (step == 4'd2 || step == 4'd3)   step_end = TW'(T_MRS - 1);
    else if (step >= 4'd5 && step <= 4'd12)  step_end = TW'(T_REF - 1);
    else if (step == LAST_STEP)              step_end = '0;
  end

  always_comb begin
    case (step)
      4'd0, 4'd1: off = ADDR_W'(32'h1F000);
      4'd2:       off = ADDR_W'(32'h2000);
      4'd3:       off = ADDR_W'(32'h800);
      4'd4:       off = ADDR_W'(32'h1F200);
      4'd13:      off = ADDR_W'({cl_code, BT_ILV, BL_CODE, 3'b000});
      default:    off = ADDR_W'(32'h1F300) + (ADDR_W'(step - 4'd5) << 8);
    endcase
  end

  always_comb begin
    case (phase)
      PH_IDLE: cmd = 3'd0;
      PH_PWR:  cmd = 3'd1;
      PH_CKE:  cmd = 3'd2;
      PH_DONE: cmd = 3'd7;
      default: begin
        case (step)
          4'd0:              cmd = 3'd3;
          4'd1, 4'd4:        cmd = 3'd4;
          4'd2, 4'd3, 4'd13: cmd = 3'd5;
          LAST_STEP:         cmd = 3'd7;
          default:           cmd = 3'd6;
        endcase
      end
    endcase
  end

  assign step_over = (timer == step_end);
  assign acc_stb   = (phase == PH_RANK) && (timer == '0) && (step != LAST_STEP);
  assign acc_addr  = base + off;
  assign done      = (phase == PH_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      step  <= '0;
      timer <= '0;
      rank  <= '0;
      last  <= '0;
      cas_q <= '0;
      base  <= '0;
    end else begin
      case (phase)
        PH_IDLE, PH_DONE: begin
          if (start) begin
            phase <= PH_PWR;
            step  <= '0;
            timer <= '0;
            rank  <= '0;
            base  <= '0;
            last  <= last_d;
            cas_q <= cas_sel;
          end
        end
        default: begin
          if (!step_over) begin
            timer <= timer + 1'b1;
          end else begin
            timer <= '0;
            if (phase == PH_PWR) begin
              phase <= PH_CKE;
            end else if (phase == PH_CKE) begin
              phase <= PH_RANK;
              step  <= '0;
            end else if (step != LAST_STEP) begin
              step <= step + 1'b1;
            end else if (rank == last) begin
              phase <= PH_DONE;
            end else begin
              step <= '0;
              rank <= rank + 1'b1;
              base <= ADDR_W'(rank_end[rank*END_W +: END_W]) << GRAN_LOG2;
            end
          end
        end
      endcase
    end
  end
endmodule

module ddr_init_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [2:0] cmd,
  input logic       acc_stb,
  input logic       done
);
  a_r1_idle_out_of_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cmd == 3'd0 && !acc_stb && !done));

  a_r2_wait_from_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd1 && $past(cmd) != 3'd1) |-> ($past(cmd) == 3'd0 || $past(cmd) == 3'd7));

  a_r2_cke_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd2 && $past(cmd) != 3'd2) |-> $past(cmd) == 3'd1);

  a_r3_refresh_after_pall: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd6 && $past(cmd) != 3'd6) |-> $past(cmd) == 3'd4);

  a_r4_strobe_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stb |-> (cmd >= 3'd3 && cmd <= 3'd6));

  a_r8_done_normal: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd == 3'd7 && !acc_stb));

  a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cmd != 3'd0 && cmd != 3'd7) |=> !(cmd == 3'd1 && $past(cmd) != 3'd1));
endmodule

bind ddr_init_seq ddr_init_seq_chk i_chk (.*);

// File: tb/test_ddr_init_seq.sv
module test_ddr_init_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TP = 12, TM = 5, TR = 7, TS = 3;

  logic        clk = 0, rst_n = 0, start = 0;
  logic [1:0]  cas_sel = 0;
  logic [2:0]  rank_cnt = 0;
  logic [31:0] rank_end = 0;
  logic [2:0]  cmd;
  logic        acc_stb, done;
  logic [31:0] acc_addr;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_init_seq #(.T_PWR(TP), .T_MRS(TM), .T_REF(TR), .T_STEP(TS)) i_ddr_init_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cas_sel(cas_sel), .rank_cnt(rank_cnt),
    .rank_end(rank_end), .cmd(cmd), .acc_stb(acc_stb), .acc_addr(acc_addr), .done(done));

  // per-rank step table: command, has access, offset (13 = mode word), length
  localparam logic [2:0]  S_CMD [0:14] = '{3, 4, 5, 5, 4, 6, 6, 6, 6, 6, 6, 6, 6, 5, 7};
  localparam bit          S_ACC [0:14] = '{1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 0};
  localparam logic [31:0] S_OFF [0:14] = '{32'h1F000, 32'h1F000, 32'h2000, 32'h800, 32'h1F200,
    32'h1F300, 32'h1F400, 32'h1F500, 32'h1F600, 32'h1F700, 32'h1F800, 32'h1F900, 32'h1FA00, 0, 0};
  localparam int          S_LEN [0:14] = '{TS, TS, TM, TM, TS, TR, TR, TR, TR, TR, TR, TR, TR, TS, 1};

  // run vectors: cas, rank count, end bytes, mid-run poke
  localparam logic [1:0]  V_CAS  [0:4] = '{0, 1, 2, 3, 0};
  localparam logic [2:0]  V_RC   [0:4] = '{1, 2, 4, 0, 7};
  localparam logic [31:0] V_END  [0:4] = '{32'h00000010, 32'h00003010, 32'h7050_2008,
                                           32'h00000004, 32'h4030_2010};
  localparam bit          V_POKE [0:4] = '{0, 1, 0, 0, 0};

  task automatic check(input bit ok, input string what, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %s expected %s", what, act, exp);
    end
  endtask

  task automatic chk_step(input logic [2:0] ecmd, input bit has_acc, input logic [31:0] eaddr,
                          input int len, input string req, input bit poke);
    bit bad = 0;
    string a_s = "", e_s = "";
    for (int c = 0; c < len; c++) begin
      logic exp_stb;
      @(negedge clk);
      if (start) start = 0;
      exp_stb = has_acc && (c == 0);
      if (!bad && (cmd !== ecmd || acc_stb !== exp_stb || done !== 1'b0 ||
                   (exp_stb && acc_addr !== eaddr))) begin
        bad = 1;
        a_s = $sformatf("cyc%0d cmd=%0d stb=%b addr=%h done=%b", c, cmd, acc_stb, acc_addr, done);
        e_s = $sformatf("cyc%0d cmd=%0d stb=%b addr=%h done=0", c, ecmd, exp_stb, eaddr);
      end
      if (poke && c == 0) begin
        start = 1;
        cas_sel = cas_sel + 2'd1;
        rank_cnt = 3'd1;
      end
    end
    check(!bad, req, a_s, e_s);
  endtask

  task automatic run_case(input logic [1:0] cas, input logic [2:0] rc, input logic [31:0] ends,
                          input bit poke);
    int n;
    logic [31:0] base, mode;
    n = (rc == 0) ? 1 : (rc > 4) ? 4 : int'(rc);
    mode = (cas == 0) ? 32'h150 : (cas == 1) ? 32'h350 : 32'h1D0;
    @(negedge clk);
    cas_sel = cas; rank_cnt = rc; rank_end = ends; start = 1;
    chk_step(3'd1, 0, 0, TP, "R2 power wait", 0);
    chk_step(3'd2, 0, 0, TP, "R2 cke on", 0);
    for (int r = 0; r < n; r++) begin
      base = (r == 0) ? 32'h0 : ({24'h0, ends[8*(r-1) +: 8]} << 24);
      for (int s = 0; s < 15; s++) begin
        string tag;
        tag = (s == 13) ? $sformatf("R5 mode rank%0d", r) :
              (s == 0 && r > 0) ? $sformatf("R7 base rank%0d", r) :
              (poke) ? $sformatf("R9 R8 step%0d rank%0d", s, r) :
                       $sformatf("R3 R4 step%0d rank%0d", s, r);
        chk_step(S_CMD[s], S_ACC[s], base + ((s == 13) ? mode : S_OFF[s]), S_LEN[s], tag,
                 poke && r == 0 && s == 5);
      end
    end
    @(negedge clk);
    check(done === 1'b1 && cmd === 3'd7 && acc_stb === 1'b0, "R6 R8 done after last rank",
          $sformatf("done=%b cmd=%0d stb=%b", done, cmd, acc_stb), "done=1 cmd=7 stb=0");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cmd === 3'd0 && acc_stb === 1'b0 && done === 1'b0, "R1 in reset",
          $sformatf("cmd=%0d stb=%b done=%b", cmd, acc_stb, done), "cmd=0 stb=0 done=0");
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(cmd === 3'd0 && acc_stb === 1'b0 && done === 1'b0, "R1 idle after reset",
          $sformatf("cmd=%0d stb=%b done=%b", cmd, acc_stb, done), "cmd=0 stb=0 done=0");

    for (int v = 0; v < 5; v++) run_case(V_CAS[v], V_RC[v], V_END[v], V_POKE[v]);

    repeat (5) @(negedge clk);
    check(done === 1'b1 && cmd === 3'd7, "R8 done held",
          $sformatf("done=%b cmd=%0d", done, cmd), "done=1 cmd=7");

    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check(cmd === 3'd0 && done === 1'b0 && acc_stb === 1'b0, "R1 reset mid-run",
          $sformatf("cmd=%0d done=%b stb=%b", cmd, done, acc_stb), "cmd=0 done=0 stb=0");
    rst_n = 1;
    run_case(2'd1, 3'd1, 32'h0, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule